// File: doc/BRIEF.md
# Circular Entry Queue with a Packed State Word

This block holds one circular queue inside a word-addressed SRAM. Every piece of the queue's setup and position sits in a single 32-bit state word. That word carries both buffer pointers, the buffer's base block, an entry-size code, a buffer-size code, and two threshold codes. Software loads the word through a register port and can read it back at any time. Because the live pointers are part of the same word, a read-back shows exactly how far the producer and the consumer have got.

A producer pushes entries of 1, 2 or 4 words, one word per cycle. A consumer pops entries the same way and receives each word one cycle after it asks for it. The size and threshold fields are logarithmic codes, and the block decodes them into word and entry counts. From those counts it drives empty, nearly-empty, nearly-full and full. Two sticky flags record a push refused because the queue was full and a pop refused because it was empty.

Top module: `packed_word_queue`

## Requirements
- R1: After synchronous reset the state word reads 0. empty and near_empty are 1. full, near_full, underflow and overflow are 0.
- R2: A cycle with cfg_we high replaces the state word with cfg_wdata, and cfg_rdata shows it from the next cycle. The field layout is: bits 6:0 write pointer, 13:7 read pointer, 21:14 base block, 23:22 entry-size code, 25:24 buffer-size code, 28:26 nearly-empty code, 31:29 nearly-full code. A state-word write also abandons any half-transferred entry.
- R3: Each push_valid cycle writes one word to SRAM word address base*16 + ((wr_ptr + k) mod buffer words), where k counts the words already sent for the current entry. Entry-size code 0 means 1 word per entry, code 1 means 2 words, and codes 2 and 3 mean 4 words.
- R4: Each pop_valid cycle reads the word at base*16 + ((rd_ptr + k) mod buffer words). pop_rvalid and pop_rdata present that word in the following cycle.
- R5: Buffer-size codes 0, 1, 2 and 3 select 16, 32, 64 and 128 words. A committed entry advances its pointer by the entry size, and the new value is masked with (buffer words − 1), so the pointer wraps.
- R6: full is 1 once the pushes fill every word of the buffer, and stays 1 until a pop commits. empty is 1 when the two pointers are equal and the buffer is not full.
- R7: near_empty is 1 when the stored entry count is at most the decoded nearly-empty threshold. Code 0 decodes to 0 entries, and code n > 0 decodes to 2^(n−1) entries.
- R8: near_full is 1 when the free entry count is at most the decoded nearly-full threshold, using the same decoding as R7.
- R9: A push whose first word arrives while full is 1 sets overflow. None of that entry's words is written, and the write pointer does not move.
- R10: A pop whose first word is requested while the queue is empty sets underflow. Each of that entry's words is returned as zero, and the read pointer does not move.
- R11: clr_underflow and clr_overflow clear their sticky flag when high. If a new refusal occurs in the same cycle, the flag stays set.
- R12: The pointers change only after the last word of an entry. Before that, the state word and the flags are the same as before the entry started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the state word |
| cfg_wdata | input | 32 | New state word |
| cfg_rdata | output | 32 | Current state word |
| push_valid | input | 1 | One pushed word this cycle |
| push_data | input | DATA_W | Pushed word |
| pop_valid | input | 1 | Request one popped word this cycle |
| pop_rvalid | output | 1 | Popped word present |
| pop_rdata | output | DATA_W | Popped word, or zero for a refused pop |
| clr_underflow | input | 1 | Clear the underflow flag |
| clr_overflow | input | 1 | Clear the overflow flag |
| empty | output | 1 | No entries stored |
| near_empty | output | 1 | Entry count at or below its threshold |
| near_full | output | 1 | Free entries at or below its threshold |
| full | output | 1 | Every buffer word is occupied |
| underflow | output | 1 | Sticky: a pop was refused |
| overflow | output | 1 | Sticky: a push was refused |

## Verification
The pointers, the state word and every flag derived from them update at the clock edge that takes the last word of an entry. A loaded state word shows on cfg_rdata at the edge that follows the write. A popped word shows one edge after its request, and a sticky flag sets at the edge that takes the refused first word. The bench drives each input just after a rising edge and reads the outputs at that same point, one edge after the stimulus. It also reads between the words of an entry, to confirm that nothing moves before the last word.

// File: rtl/pwq_pkg.sv
package pwq_pkg;

    // Packed state word: fields listed MSB first.
    typedef struct packed {
        logic [2:0] nf_code;
        logic [2:0] ne_code;
        logic [1:0] buf_code;
        logic [1:0] ent_code;
        logic [7:0] base_blk;
        logic [6:0] rd_ptr;
        logic [6:0] wr_ptr;
    } qword_t;

    localparam int unsigned BLOCK_WORDS_LOG2 = 4;

    function automatic logic [1:0] ent_shift(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [2:0] ent_words(input logic [1:0] code);
        return 3'd1 << ent_shift(code);
    endfunction

    function automatic logic [7:0] buf_words(input logic [1:0] code);
        return 8'd16 << code;
    endfunction

    function automatic logic [7:0] wm_entries(input logic [2:0] code);
        return (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
    endfunction

    function automatic logic [6:0] ptr_step(input logic [6:0] ptr,
                                            input logic [6:0] amount,
                                            input logic [1:0] bcode);
        logic [7:0] m;
        m = buf_words(bcode) - 8'd1;
        return (ptr + amount) & m[6:0];
    endfunction

endpackage

// File: rtl/pwq_sram.sv
module pwq_sram #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/pwq_beat_seq.sv
module pwq_beat_seq (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       beat,
    input  logic       blocked,
    input  logic [2:0] words,
    output logic [1:0] offset,
    output logic       drop_now,
    output logic       commit,
    output logic       refused
);
    logic [1:0] cnt;
    logic       drop_r;
    logic       first;
    logic       last;

    always_comb begin
        first    = (cnt == 2'd0);
        last     = ({1'b0, cnt} == (words - 3'd1));
        drop_now = first ? blocked : drop_r;
        commit   = beat & last & ~drop_now;
        refused  = beat & first & blocked;
        offset   = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt    <= 2'd0;
            drop_r <= 1'b0;
        end else if (beat) begin
            cnt    <= last ? 2'd0 : cnt + 2'd1;
            drop_r <= drop_now;
        end
    end

    // R12: the word counter moves only on a word
    assert_seq_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!beat && !flush) |=> $stable(cnt));
    // R3: the word index stays inside the entry
    assert_seq_bound_R3: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} < words));
endmodule

// File: rtl/pwq_level.sv
module pwq_level
    import pwq_pkg::*;
(
    input  qword_t q,
    input  logic   full_r,
    output logic   empty,
    output logic   near_empty,
    output logic   near_full,
    output logic   full
);
    logic [7:0] bw, mask, used, ents, cap, free_e;
    logic [6:0] diff;
    logic [1:0] sh;

    always_comb begin
        bw         = buf_words(q.buf_code);
        mask       = bw - 8'd1;
        sh         = ent_shift(q.ent_code);
        diff       = (q.wr_ptr - q.rd_ptr) & mask[6:0];
        used       = full_r ? bw : {1'b0, diff};
        ents       = used >> sh;
        cap        = bw >> sh;
        free_e     = cap - ents;
        full       = full_r;
        empty      = ~full_r & (used == 8'd0);
        near_empty = (ents <= wm_entries(q.ne_code));
        near_full  = (free_e <= wm_entries(q.nf_code));
    end
endmodule

// File: rtl/packed_word_queue.sv
module packed_word_queue
    import pwq_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SRAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_valid,
    output logic              pop_rvalid,
    output logic [DATA_W-1:0] pop_rdata,
    input  logic              clr_underflow,
    input  logic              clr_overflow,
    output logic              empty,
    output logic              near_empty,
    output logic              near_full,
    output logic              full,
    output logic              underflow,
    output logic              overflow
);
    qword_t q;
    logic   full_r;
    logic   zero_r;
    logic [2:0] ew;
    logic [1:0] push_off, pop_off;
    logic   push_drop, pop_drop, push_commit, pop_commit, push_refused, pop_refused;
    logic [6:0] wr_next, rd_next;
    logic [SRAM_AW-1:0] waddr, raddr;
    logic [DATA_W-1:0]  mem_rdata;

    function automatic logic [SRAM_AW-1:0] word_addr(input qword_t s,
                                                     input logic [6:0] ptr,
                                                     input logic [1:0] off);
        logic [6:0] p;
        p = ptr_step(ptr, {5'd0, off}, s.buf_code);
        return SRAM_AW'({s.base_blk, {BLOCK_WORDS_LOG2{1'b0}}}) + SRAM_AW'(p);
    endfunction

    assign ew        = ent_words(q.ent_code);
    assign wr_next   = ptr_step(q.wr_ptr, {4'd0, ew}, q.buf_code);
    assign rd_next   = ptr_step(q.rd_ptr, {4'd0, ew}, q.buf_code);
    assign waddr     = word_addr(q, q.wr_ptr, push_off);
    assign raddr     = word_addr(q, q.rd_ptr, pop_off);
    assign cfg_rdata = q;
    assign pop_rdata = zero_r ? '0 : mem_rdata;

    pwq_level u_level (
        .q(q), .full_r(full_r), .empty(empty), .near_empty(near_empty),
        .near_full(near_full), .full(full)
    );

    pwq_beat_seq u_push (
        .clk(clk), .rst(rst), .flush(cfg_we), .beat(push_valid), .blocked(full),
        .words(ew), .offset(push_off), .drop_now(push_drop),
        .commit(push_commit), .refused(push_refused)
    );

    pwq_beat_seq u_pop (
        .clk(clk), .rst(rst), .flush(cfg_we), .beat(pop_valid), .blocked(empty),
        .words(ew), .offset(pop_off), .drop_now(pop_drop),
        .commit(pop_commit), .refused(pop_refused)
    );

    pwq_sram #(.AW(SRAM_AW), .DW(DATA_W)) u_sram (
        .clk(clk), .we(push_valid & ~push_drop), .waddr(waddr), .wdata(push_data),
        .re(pop_valid & ~pop_drop), .raddr(raddr), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            full_r <= 1'b0;
        end else if (cfg_we) begin
            q      <= qword_t'(cfg_wdata);
            full_r <= 1'b0;
        end else begin
            if (push_commit) q.wr_ptr <= wr_next;
            if (pop_commit)  q.rd_ptr <= rd_next;
            if (push_commit && !pop_commit && wr_next == q.rd_ptr) full_r <= 1'b1;
            else if (pop_commit && !push_commit)                   full_r <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_rvalid <= 1'b0;
            zero_r     <= 1'b0;
            underflow  <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            pop_rvalid <= pop_valid;
            zero_r     <= pop_valid & pop_drop;
            underflow  <= (underflow & ~clr_underflow) | pop_refused;
            overflow   <= (overflow & ~clr_overflow) | push_refused;
        end
    end

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));
    assert_no_commit_full_R9: assert property (@(posedge clk) disable iff (rst)
        push_commit |-> !full);
    assert_pop_latency_R4: assert property (@(posedge clk) disable iff (rst)
        pop_valid |=> pop_rvalid);
    assert_under_zero_R10: assert property (@(posedge clk) disable iff (rst)
        pop_refused |=> (underflow && pop_rdata == '0));
    assert_over_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (overflow && !clr_overflow) |=> overflow);
    assert_wr_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!push_commit && !cfg_we) |=> $stable(q.wr_ptr));
    assert_full_nf_R8: assert property (@(posedge clk) disable iff (rst)
        full |-> near_full);
    assert_empty_ne_R7: assert property (@(posedge clk) disable iff (rst)
        empty |-> near_empty);
endmodule

// File: tb/tb_packed_word_queue.sv
module tb_packed_word_queue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop_valid = 1'b0;
    logic        pop_rvalid;
    logic [31:0] pop_rdata;
    logic        clr_underflow = 1'b0;
    logic        clr_overflow = 1'b0;
    logic        empty, near_empty, near_full, full, underflow, overflow;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    packed_word_queue dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .push_valid(push_valid), .push_data(push_data),
        .pop_valid(pop_valid), .pop_rvalid(pop_rvalid), .pop_rdata(pop_rdata),
        .clr_underflow(clr_underflow), .clr_overflow(clr_overflow),
        .empty(empty), .near_empty(near_empty), .near_full(near_full),
        .full(full), .underflow(underflow), .overflow(overflow)
    );

    function automatic logic [31:0] mk(input logic [2:0] nf, input logic [2:0] ne,
                                       input logic [1:0] bc, input logic [1:0] ec,
                                       input logic [7:0] base, input logic [6:0] rd,
                                       input logic [6:0] wr);
        return {nf, ne, bc, ec, base, rd, wr};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic push_words(input int n, input logic [31:0] d0);
        for (int k = 0; k < n; k++) begin
            push_valid = 1'b1; push_data = d0 + 32'(k);
            tick();
        end
        push_valid = 1'b0;
    endtask

    task automatic pop_words(input int n, input logic [31:0] d0, input string req);
        for (int k = 0; k < n; k++) begin
            pop_valid = 1'b1;
            tick();
            chk(req, {31'd0, pop_rvalid}, 32'd1);
            chk(req, pop_rdata, d0 + 32'(k));
        end
        pop_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 state word", cfg_rdata, 32'd0);
        chk("R1 flags", {26'd0, empty, near_empty, near_full, full, underflow, overflow},
            32'b110000);
    endtask

    task automatic t_two_word();
        logic [31:0] w;
        w = mk(3'd3, 3'd2, 2'd1, 2'd1, 8'd5, 7'd0, 7'd0);
        load(w);
        chk("R2 readback", cfg_rdata, w);
        push_words(1, 32'hA0);
        chk("R12 mid-entry word", cfg_rdata, w);
        chk("R12 mid-entry empty", {31'd0, empty}, 32'd1);
        push_data = 32'hA1; push_valid = 1'b1; tick(); push_valid = 1'b0;
        chk("R3 wr after 2-word entry", cfg_rdata, mk(3'd3, 3'd2, 2'd1, 2'd1, 8'd5, 7'd0, 7'd2));
        chk("R7 one entry near_empty", {30'd0, empty, near_empty}, 32'b01);
        push_words(2, 32'hB0);
        push_words(2, 32'hC0);
        chk("R7 three entries above threshold", {30'd0, near_empty, near_full}, 32'b00);
        pop_words(2, 32'hA0, "R4 pop 2-word entry");
        chk("R4 rd after pop", cfg_rdata, mk(3'd3, 3'd2, 2'd1, 2'd1, 8'd5, 7'd2, 7'd6));
        chk("R7 two entries near_empty", {31'd0, near_empty}, 32'd1);
    endtask

    task automatic t_underflow();
        load(mk(3'd0, 3'd0, 2'd0, 2'd0, 8'd0, 7'd0, 7'd0));
        pop_valid = 1'b1; tick(); pop_valid = 1'b0;
        chk("R10 zero data", pop_rdata, 32'd0);
        chk("R10 underflow set", {31'd0, underflow}, 32'd1);
        chk("R10 rd unchanged", cfg_rdata, 32'd0);
        clr_underflow = 1'b1; tick(); clr_underflow = 1'b0;
        chk("R11 clear underflow", {31'd0, underflow}, 32'd0);
        clr_underflow = 1'b1; pop_valid = 1'b1; tick();
        clr_underflow = 1'b0; pop_valid = 1'b0;
        chk("R11 set wins over clear", {31'd0, underflow}, 32'd1);
        clr_underflow = 1'b1; tick(); clr_underflow = 1'b0;
    endtask

    task automatic t_full_wrap();
        load(mk(3'd2, 3'd0, 2'd0, 2'd0, 8'd2, 7'd14, 7'd14));
        push_words(1, 32'd100);
        chk("R7 code 0 one entry", {31'd0, near_empty}, 32'd0);
        push_words(12, 32'd101);
        chk("R8 free 3 above threshold", {31'd0, near_full}, 32'd0);
        push_words(1, 32'd113);
        chk("R8 free 2 at threshold", {31'd0, near_full}, 32'd1);
        push_words(2, 32'd114);
        chk("R6 full", {30'd0, full, empty}, 32'b10);
        chk("R5 wr wrapped", cfg_rdata, mk(3'd2, 3'd0, 2'd0, 2'd0, 8'd2, 7'd14, 7'd14));
        push_words(1, 32'd999);
        chk("R9 overflow set", {31'd0, overflow}, 32'd1);
        chk("R9 wr unchanged", cfg_rdata, mk(3'd2, 3'd0, 2'd0, 2'd0, 8'd2, 7'd14, 7'd14));
        pop_words(16, 32'd100, "R9 R5 data intact through wrap");
        chk("R6 empty after drain", {30'd0, full, empty}, 32'b01);
        clr_overflow = 1'b1; tick(); clr_overflow = 1'b0;
        chk("R11 clear overflow", {31'd0, overflow}, 32'd0);
    endtask

    task automatic t_four_word();
        load(mk(3'd0, 3'd1, 2'd3, 2'd2, 8'd0, 7'd124, 7'd124));
        push_words(3, 32'h40);
        chk("R12 three of four words", {31'd0, empty}, 32'd1);
        push_words(1, 32'h43);
        chk("R5 128-word wrap", cfg_rdata, mk(3'd0, 3'd1, 2'd3, 2'd2, 8'd0, 7'd124, 7'd0));
        chk("R7 code 1 one entry", {31'd0, near_empty}, 32'd1);
        pop_words(4, 32'h40, "R3 R4 four-word entry");
        chk("R4 rd wrapped", cfg_rdata, mk(3'd0, 3'd1, 2'd3, 2'd2, 8'd0, 7'd0, 7'd0));
    endtask

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_two_word();
        t_underflow();
        t_full_wrap();
        t_four_word();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule